// File: doc/BRIEF.md
# Chainable Multi-Channel Down Timer

A bank of down-counting timers behind a small word-addressed register port. Each channel owns a counter, a reload value, a control word and a snapshot register. All channels share one count-enable tick input. A channel can instead take its count pulses from underflows of the channel below it, so neighbouring channels join into one wider counter.

On underflow a channel can reload itself or wrap to all ones. If its interrupt enable is set, it raises a sticky pending flag that software clears by writing one. A debug-halt input freezes every counter while it is high. A one-cycle snapshot strobe copies all counters into their snapshot registers on the same edge.

Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `cascade_timer_bank`

## Requirements
- R1: Channel n occupies byte addresses n*16 + 0x0 (counter), +0x4 (reload), +0x8 (control) and +0xC (snapshot). After reset every counter, reload, control and snapshot register reads as zero.
- R2: The reload register keeps only its low RLD_W bits (default 24). The upper bits read as zero.
- R3: The control word is laid out as bit 0 enable, bit 1 auto-reload, bit 2 load strobe, bit 3 interrupt enable, bit 4 pending and bit 6 halt mirror. Bit 5 is the chain select. Bits 31..7 and the load strobe bit always read as zero.
- R4: Writing a control word with bit 2 set copies the reload value into the counter on that edge.
- R5: An enabled channel decrements once per cycle in which its count source is high. A disabled channel never changes its count and reports no underflow.
- R6: A decrement from zero is an underflow. With auto-reload clear the counter wraps to all ones. With auto-reload set it loads the reload value.
- R7: With chain select set, channel n>0 counts on underflows of channel n-1 in the same cycle instead of on the tick. Channel 0 has no chain select: its bit 5 reads as zero and it always counts on the tick.
- R8: An underflow with interrupt enable set sets the pending flag. The flag stays set until a control write with bit 4 = 1 clears it. Writing 0 to bit 4 leaves it unchanged. An underflow wins over a clear in the same cycle. Output irq_o[n] shows channel n's pending flag.
- R9: While halt_i is high no counter decrements. Control bit 6 reads the current halt_i.
- R10: A high latch_i copies every counter into its snapshot register on the same edge. Bus writes to a snapshot address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Shared count pulse |
| halt_i | input | 1 | Debug halt, freezes all counters |
| latch_i | input | 1 | Snapshot strobe for all channels |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | NUM_TIMERS | Pending flags, one per channel |

## Verification
The collision of interest is a channel underflowing with its interrupt enabled in the same cycle that software writes one to the pending bit. The bench sets that channel's counter to zero and enables it. It then asserts the tick and the clearing control write on the same edge. The pending flag must still read as one afterwards, and irq_o must stay high. The behavioural reference model applies the same set-before-clear rule, and it is compared on every clock.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
   typedef enum logic [1:0] {
      SEL_COUNT  = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_SNAP   = 2'd3
   } reg_sel_e;

   localparam int CB_EN   = 0;
   localparam int CB_ARLD = 1;
   localparam int CB_LOAD = 2;
   localparam int CB_IEN  = 3;
   localparam int CB_PEND = 4;
   localparam int CB_CHN  = 5;
   localparam int CB_HALT = 6;
endpackage

// File: rtl/timer_chan.sv
module timer_chan
   import cascade_timer_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int RLD_W    = 24,
   parameter bit HAS_PREV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             halt_i,
   input  logic             prev_uf_i,
   input  logic             latch_i,
   input  logic             wr_cnt_i,
   input  logic             wr_rld_i,
   input  logic             wr_ctl_i,
   input  logic [31:0]      wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [RLD_W-1:0] rld_o,
   output logic [CNT_W-1:0] snap_o,
   output logic [CB_CHN:0]  ctl_o,
   output logic             uf_o
);
   logic [CNT_W-1:0] cnt_q, snap_q, rld_ext;
   logic [RLD_W-1:0] rld_q;
   logic             en_q, arld_q, ien_q, pend_q, chn_q;
   logic             src, step, load_req;
   logic             unused_wdata;

   assign unused_wdata = ^wdata_i;
   assign rld_ext  = CNT_W'(rld_q);
   assign load_req = wr_ctl_i && wdata_i[CB_LOAD];

   if (HAS_PREV) begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)        chn_q <= 1'b0;
         else if (wr_ctl_i) chn_q <= wdata_i[CB_CHN];
      assign src = chn_q ? prev_uf_i : tick_i;
   end else begin : g_head
      assign chn_q = 1'b0;
      assign src   = tick_i;
   end

   assign step = en_q && !halt_i && src;
   assign uf_o = step && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        cnt_q <= '0;
      else if (wr_cnt_i) cnt_q <= wdata_i[CNT_W-1:0];
      else if (load_req) cnt_q <= rld_ext;
      else if (uf_o)     cnt_q <= arld_q ? rld_ext : '1;
      else if (step)     cnt_q <= cnt_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         en_q <= 1'b0; arld_q <= 1'b0; ien_q <= 1'b0;
      end else if (wr_ctl_i) begin
         en_q   <= wdata_i[CB_EN];
         arld_q <= wdata_i[CB_ARLD];
         ien_q  <= wdata_i[CB_IEN];
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                pend_q <= 1'b0;
      else if (uf_o && ien_q)                    pend_q <= 1'b1;
      else if (wr_ctl_i && wdata_i[CB_PEND])     pend_q <= 1'b0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        rld_q <= '0;
      else if (wr_rld_i) rld_q <= wdata_i[RLD_W-1:0];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       snap_q <= '0;
      else if (latch_i) snap_q <= cnt_q;

   assign cnt_o  = cnt_q;
   assign rld_o  = rld_q;
   assign snap_o = snap_q;
   assign ctl_o  = {chn_q, pend_q, ien_q, 1'b0, arld_q, en_q};

   assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !(wr_ctl_i && wdata_i[CB_PEND]) |=> pend_q);
   assert_pend_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      uf_o && ien_q |=> pend_q);
   assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i && !wr_cnt_i && !load_req |=> $stable(cnt_q));
   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      uf_o && !arld_q && !wr_cnt_i && !load_req |=> &cnt_q);
   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      uf_o && arld_q && !wr_cnt_i && !load_req |=> cnt_q == CNT_W'($past(rld_q)));
   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_req && !wr_cnt_i |=> cnt_q == CNT_W'($past(rld_q)));
   assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q && !wr_cnt_i && !load_req |=> $stable(cnt_q));
   assert_snap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      latch_i |=> snap_q == $past(cnt_q));
endmodule

// File: rtl/timer_regmux.sv
module timer_regmux
   import cascade_timer_pkg::*;
#(
   parameter int NUM_TIMERS = 4,
   parameter int CNT_W      = 32,
   parameter int RLD_W      = 24,
   parameter int ADDR_W     = 6
) (
   input  logic [ADDR_W-1:0]                  addr_i,
   input  logic                               halt_i,
   input  logic [NUM_TIMERS-1:0][CNT_W-1:0]   cnt_i,
   input  logic [NUM_TIMERS-1:0][RLD_W-1:0]   rld_i,
   input  logic [NUM_TIMERS-1:0][CNT_W-1:0]   snap_i,
   input  logic [NUM_TIMERS-1:0][CB_CHN:0]    ctl_i,
   output logic [31:0]                        rdata_o
);
   localparam int IDX_W = ADDR_W - 4;
   logic [IDX_W-1:0] idx;
   logic             unused_lsb;

   assign idx        = addr_i[ADDR_W-1:4];
   assign unused_lsb = ^addr_i[1:0];

   always_comb begin
      rdata_o = '0;
      if (int'(idx) < NUM_TIMERS) begin
         case (reg_sel_e'(addr_i[3:2]))
            SEL_COUNT:  rdata_o = 32'(cnt_i[idx]);
            SEL_RELOAD: rdata_o = 32'(rld_i[idx]);
            SEL_CTRL: begin
               rdata_o[CB_CHN:0] = ctl_i[idx];
               rdata_o[CB_HALT]  = halt_i;
            end
            default:    rdata_o = 32'(snap_i[idx]);
         endcase
      end
   end
endmodule

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank
   import cascade_timer_pkg::*;
#(
   parameter  int NUM_TIMERS = 4,
   parameter  int CNT_W      = 32,
   parameter  int RLD_W      = 24,
   localparam int ADDR_W     = $clog2(NUM_TIMERS) + 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_i,
   input  logic                  halt_i,
   input  logic                  latch_i,
   input  logic                  bus_wr_i,
   input  logic [ADDR_W-1:0]     bus_addr_i,
   input  logic [31:0]           bus_wdata_i,
   output logic [31:0]           bus_rdata_o,
   output logic [NUM_TIMERS-1:0] irq_o
);
   if (NUM_TIMERS < 2 || NUM_TIMERS > 16) begin : g_bad_count
      $error("NUM_TIMERS must lie in 2..16");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (RLD_W < 1 || RLD_W > CNT_W) begin : g_bad_rld
      $error("RLD_W must lie in 1..CNT_W");
   end

   logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_all, snap_all;
   logic [NUM_TIMERS-1:0][RLD_W-1:0] rld_all;
   logic [NUM_TIMERS-1:0][CB_CHN:0]  ctl_all;
   logic [NUM_TIMERS-1:0]            uf, prev_uf;
   logic [ADDR_W-5:0]                wr_idx;
   reg_sel_e                         wr_sel;

   assign wr_idx  = bus_addr_i[ADDR_W-1:4];
   assign wr_sel  = reg_sel_e'(bus_addr_i[3:2]);
   assign prev_uf = {uf[NUM_TIMERS-2:0], 1'b0};

   for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_chan
      logic hit;
      assign hit = bus_wr_i && (int'(wr_idx) == n);

      timer_chan #(
         .CNT_W    (CNT_W),
         .RLD_W    (RLD_W),
         .HAS_PREV (n > 0)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_i    (tick_i),
         .halt_i    (halt_i),
         .prev_uf_i (prev_uf[n]),
         .latch_i   (latch_i),
         .wr_cnt_i  (hit && wr_sel == SEL_COUNT),
         .wr_rld_i  (hit && wr_sel == SEL_RELOAD),
         .wr_ctl_i  (hit && wr_sel == SEL_CTRL),
         .wdata_i   (bus_wdata_i),
         .cnt_o     (cnt_all[n]),
         .rld_o     (rld_all[n]),
         .snap_o    (snap_all[n]),
         .ctl_o     (ctl_all[n]),
         .uf_o      (uf[n])
      );

      assign irq_o[n] = ctl_all[n][CB_PEND];
   end

   timer_regmux #(
      .NUM_TIMERS (NUM_TIMERS),
      .CNT_W      (CNT_W),
      .RLD_W      (RLD_W),
      .ADDR_W     (ADDR_W)
   ) u_regmux (
      .addr_i  (bus_addr_i),
      .halt_i  (halt_i),
      .cnt_i   (cnt_all),
      .rld_i   (rld_all),
      .snap_i  (snap_all),
      .ctl_i   (ctl_all),
      .rdata_o (bus_rdata_o)
   );

   assert_halt_no_uf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |-> uf == '0);
   assert_head_no_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_all[0][CB_CHN] == 1'b0);
endmodule

// File: tb/cascade_timer_bank_test.sv
`timescale 1ns/1ps
module cascade_timer_bank_test;
   localparam int N  = 4;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0, halt = 1'b0, latch = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  irq;

   int checks = 0;
   int fails  = 0;
   bit running = 1'b0;

   always #2.5 clk = ~clk;

   cascade_timer_bank uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .halt_i(halt), .latch_i(latch),
      .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .irq_o(irq)
   );

   // reference model
   logic [31:0] m_cnt[N], m_rld[N], m_snap[N];
   bit          m_en[N], m_ar[N], m_ie[N], m_ip[N], m_ch[N];
   bit          t_uf[N], t_stp[N], t_src, t_hit;
   logic [1:0]  t_sel;

   initial for (int n = 0; n < N; n++) begin
      m_cnt[n] = 0; m_rld[n] = 0; m_snap[n] = 0;
      m_en[n] = 0; m_ar[n] = 0; m_ie[n] = 0; m_ip[n] = 0; m_ch[n] = 0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < N; n++) begin
            m_cnt[n] = 0; m_rld[n] = 0; m_snap[n] = 0;
            m_en[n] = 0; m_ar[n] = 0; m_ie[n] = 0; m_ip[n] = 0; m_ch[n] = 0;
         end
      end else begin
         for (int n = 0; n < N; n++) begin
            t_src    = (n > 0 && m_ch[n]) ? t_uf[n-1] : tick;
            t_stp[n] = m_en[n] && !halt && t_src;
            t_uf[n]  = t_stp[n] && (m_cnt[n] == 0);
         end
         t_sel = bus_addr[3:2];
         for (int n = 0; n < N; n++) begin
            t_hit = bus_wr && (int'(bus_addr[5:4]) == n);
            if (latch) m_snap[n] = m_cnt[n];
            if (t_hit && t_sel == 2'd0) m_cnt[n] = bus_wdata;
            else if (t_hit && t_sel == 2'd2 && bus_wdata[2]) m_cnt[n] = m_rld[n];
            else if (t_uf[n]) m_cnt[n] = m_ar[n] ? m_rld[n] : 32'hFFFF_FFFF;
            else if (t_stp[n]) m_cnt[n] = m_cnt[n] - 1;
            if (t_uf[n] && m_ie[n]) m_ip[n] = 1;
            else if (t_hit && t_sel == 2'd2 && bus_wdata[4]) m_ip[n] = 0;
            if (t_hit && t_sel == 2'd1) m_rld[n] = bus_wdata & 32'h00FF_FFFF;
            if (t_hit && t_sel == 2'd2) begin
               m_en[n] = bus_wdata[0]; m_ar[n] = bus_wdata[1];
               m_ie[n] = bus_wdata[3]; m_ch[n] = (n > 0) && bus_wdata[5];
            end
         end
      end
   end

   function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
      int n = int'(a[5:4]);
      case (a[3:2])
         2'd0: return m_cnt[n];
         2'd1: return m_rld[n];
         2'd2: return {25'd0, halt, m_ch[n], m_ip[n], m_ie[n], 1'b0, m_ar[n], m_en[n]};
         default: return m_snap[n];
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   always @(negedge clk) if (running) begin
      logic [N-1:0] e;
      for (int n = 0; n < N; n++) e[n] = m_ip[n];
      check("R8 irq_o vs model", 32'(irq), 32'(e));
   end

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd_lit(string tag, logic [AW-1:0] a, logic [31:0] exp);
      @(negedge clk); bus_addr = a; #1;
      check(tag, bus_rdata, exp);
      check({tag, " model"}, bus_rdata, exp_rd(a));
   endtask

   task automatic rd_mod(string tag, logic [AW-1:0] a);
      @(negedge clk); bus_addr = a; #1;
      check(tag, bus_rdata, exp_rd(a));
   endtask

   task automatic ticks(int k);
      repeat (k) begin @(negedge clk); tick = 1; end
      @(negedge clk); tick = 0;
   endtask

   function automatic logic [AW-1:0] ad(int n, int r);
      return AW'(n * 16 + r * 4);
   endfunction

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1; running = 1;
      // R1 reset state
      for (int n = 0; n < N; n++)
         for (int r = 0; r < 4; r++) rd_lit("R1 reset", ad(n, r), 32'h0);
      // R1 map
      wr(ad(1, 0), 32'h1234_5678);
      rd_lit("R1 counter rw", ad(1, 0), 32'h1234_5678);
      wr(ad(2, 1), 32'h00AB_CDEF);
      rd_lit("R1 reload rw", ad(2, 1), 32'h00AB_CDEF);
      // R2
      wr(ad(0, 1), 32'hFFFF_FFFF);
      rd_lit("R2 reload upper zero", ad(0, 1), 32'h00FF_FFFF);
      // R3 / R4
      wr(ad(1, 2), 32'hFFFF_FFFF);
      rd_lit("R3 ctrl layout", ad(1, 2), 32'h0000_002B);
      rd_lit("R4 load from reload", ad(1, 0), 32'h0);
      wr(ad(1, 2), 32'h0);
      wr(ad(0, 1), 32'h10);
      wr(ad(0, 2), 32'h4);
      rd_lit("R4 load strobe", ad(0, 0), 32'h10);
      rd_lit("R3 load reads zero", ad(0, 2), 32'h0);
      // R5
      wr(ad(0, 2), 32'h1);
      ticks(5);
      rd_lit("R5 count down", ad(0, 0), 32'h0B);
      wr(ad(0, 2), 32'h0);
      ticks(3);
      rd_lit("R5 disabled holds", ad(0, 0), 32'h0B);
      // R6
      wr(ad(0, 0), 32'h0);
      wr(ad(0, 2), 32'h1);
      ticks(1);
      rd_lit("R6 wrap", ad(0, 0), 32'hFFFF_FFFF);
      wr(ad(0, 0), 32'h0);
      wr(ad(0, 2), 32'h3);
      ticks(1);
      rd_lit("R6 auto reload", ad(0, 0), 32'h10);
      // R7 chain
      wr(ad(0, 2), 32'h0);
      wr(ad(0, 1), 32'h2);
      wr(ad(0, 0), 32'h2);
      wr(ad(1, 0), 32'd10);
      wr(ad(1, 2), 32'h21);
      wr(ad(0, 2), 32'h3);
      ticks(9);
      rd_lit("R7 chained count", ad(1, 0), 32'd7);
      rd_lit("R7 head after reloads", ad(0, 0), 32'd2);
      wr(ad(0, 2), 32'h21);
      rd_lit("R7 head chain bit zero", ad(0, 2), 32'h1);
      ticks(2);
      rd_lit("R7 head counts on tick", ad(0, 0), 32'd0);
      rd_lit("R7 no underflow no chain step", ad(1, 0), 32'd7);
      wr(ad(0, 2), 32'h0);
      wr(ad(1, 2), 32'h0);
      // R8 pending
      wr(ad(2, 0), 32'h1);
      wr(ad(2, 2), 32'h9);
      ticks(2);
      rd_lit("R8 pending set", ad(2, 2), 32'h19);
      check("R8 irq high", 32'(irq[2]), 32'h1);
      wr(ad(2, 2), 32'h09);
      rd_lit("R8 write zero keeps", ad(2, 2), 32'h19);
      wr(ad(2, 2), 32'h19);
      rd_lit("R8 write one clears", ad(2, 2), 32'h09);
      wr(ad(2, 0), 32'h0);
      @(negedge clk); bus_wr = 1; bus_addr = ad(2, 2); bus_wdata = 32'h19; tick = 1;
      @(negedge clk); bus_wr = 0; tick = 0;
      rd_lit("R8 set beats clear", ad(2, 2), 32'h19);
      check("R8 irq after collision", 32'(irq[2]), 32'h1);
      // R10 snapshot
      wr(ad(0, 0), 32'd100);
      wr(ad(0, 2), 32'h1);
      wr(ad(3, 0), 32'd50);
      wr(ad(3, 2), 32'h1);
      ticks(4);
      @(negedge clk); latch = 1;
      @(negedge clk); latch = 0;
      rd_lit("R10 snap ch0", ad(0, 3), 32'd96);
      rd_lit("R10 snap ch3", ad(3, 3), 32'd46);
      rd_mod("R10 snap ch1", ad(1, 3));
      rd_mod("R10 snap ch2", ad(2, 3));
      ticks(2);
      rd_lit("R10 snap holds", ad(0, 3), 32'd96);
      rd_lit("R10 counter moved", ad(0, 0), 32'd94);
      wr(ad(1, 3), 32'h0000_DEAD);
      rd_lit("R10 snap write ignored", ad(1, 3), 32'd7);
      // R9 halt
      @(negedge clk); halt = 1;
      ticks(3);
      rd_lit("R9 halt freezes", ad(0, 0), 32'd94);
      rd_lit("R9 halt mirror", ad(0, 2), 32'h41);
      @(negedge clk); halt = 0;
      rd_lit("R9 mirror clear", ad(0, 2), 32'h01);
      for (int n = 0; n < N; n++)
         for (int r = 0; r < 4; r++) rd_mod("R1 final scan", ad(n, r));
      running = 0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule